// File: doc/BRIEF.md
# Serial Flash Status Register with Protection Lockdown

This block keeps the eight-bit status register of a serial flash device and rules on every attempt to change it. A command decoder in front of it hands over one-cycle strobes for write enable, write disable, status-write arming, status write (with its data byte) and any other command, plus completion events from the program and erase engine. The block owns the write-enable latch, the three-bit protect code and the lock bit, and mirrors the busy and auto-increment flags coming from the engine.

Changing the register needs two things. First, the status write must be armed by a write-enable or arming strobe, with no other command strobe in between. Second, the lock bit must be clear, unless the write-protect pin (active low) is high. While the pin is low, the lock bit can only go from 0 to 1. The block also turns the protect code into an answer for one address: is it inside the protected region, which sits at the top or at the bottom of the array. It also says whether a whole-array erase may start.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status reads 0x1C. The layout is: bit0 busy, bit1 write-enable latch, bits 4:2 protect code (bit2 is its LSB), bit5 reserved and always 0, bit6 auto-increment flag, bit7 lock bit.
- R2: A write-enable strobe sets bit1. A write-disable strobe or an `op_done` pulse clears it. When `op_done` and write-enable come in the same cycle, bit1 ends at 1.
- R3: A status write changes the register only if the latest earlier command strobe was write enable or status-write arming. Idle cycles in between keep the arming. Any other command strobe in between (write disable, other) cancels it, and the write is then ignored.
- R4: An accepted status write loads bits 7 and 4:2 from `wr_data` and ignores data bits 0, 1, 5 and 6. It also clears bit1.
- R5: With `wp_n`=0 and lock bit 1, a status write is ignored and the whole status register is unchanged.
- R6: With `wp_n`=0 and lock bit 0, one status write can set the lock bit and change the protect code together.
- R7: With `wp_n`=1 the lock bit has no effect: all four writable bits, including the lock bit itself, can be changed.
- R8: With top protection (`prot_bottom`=0), protect code n in 1..5 protects the array offsets (the low ARRAY_AW address bits) whose top 6-n bits are all ones. Codes 6 and 7 protect everything and code 0 protects nothing. Address bits above ARRAY_AW are ignored.
- R9: With bottom protection (`prot_bottom`=1), the same codes protect the offsets whose top 6-n bits are all zeros.
- R10: `chip_erase_ok` is 1 exactly when the protect code is 0.
- R11: Bits 0 and 6 show `busy_in` and `aai_in` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr_en | input | 1 | Write-enable command strobe |
| cmd_wr_dis | input | 1 | Write-disable command strobe |
| cmd_sr_arm | input | 1 | Status-write arming command strobe |
| cmd_sr_write | input | 1 | Status write command strobe |
| cmd_other | input | 1 | Strobe for any other decoded command |
| wr_data | input | 8 | Data byte of the status write |
| op_done | input | 1 | Program, erase or auto-increment sequence finished |
| busy_in | input | 1 | Internal write operation in progress |
| aai_in | input | 1 | Auto-increment programming mode active |
| wp_n | input | 1 | Write-protect pin, active low |
| prot_bottom | input | 1 | 1 = protected region grows from the bottom |
| chk_addr | input | ADDR_W | Address to classify |
| status | output | 8 | Status register value |
| addr_prot | output | 1 | `chk_addr` lies in the protected region |
| chip_erase_ok | output | 1 | A whole-array erase is permitted |

## Verification
Two events can land in the same clock edge. The write-enable latch can be set by a write-enable strobe and cleared by an operation-completion pulse on that edge. A status write can also find its arming cancelled by an intervening command, or blocked by the lock bit while the pin is low. The bench drives `cmd_wr_en` and `op_done` in one cycle and expects the latch at 1. For the arming case it puts write-disable or other strobes, as well as plain idle cycles, between the arming and the status write, then reads back the register to see whether the write landed. The protection decoder is walked with addresses on both sides of every region boundary, for both top and bottom placement.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
   localparam int SR_W        = 8;
   localparam int SR_BUSY     = 0;
   localparam int SR_WLATCH   = 1;
   localparam int SR_PCODE_LO = 2;
   localparam int PCODE_W     = 3;
   localparam int SR_PCODE_HI = SR_PCODE_LO + PCODE_W - 1;
   localparam int SR_RSVD     = 5;
   localparam int SR_AAI      = 6;
   localparam int SR_LOCK     = 7;
   localparam int NUM_LVL     = 5;
   localparam logic [PCODE_W-1:0] PCODE_RESET = '1;

   typedef enum logic [1:0] {
      SIDE_PIN    = 2'd0,
      SIDE_TOP    = 2'd1,
      SIDE_BOTTOM = 2'd2
   } side_sel_e;
endpackage

// File: rtl/flash_sr_arm.sv
module flash_sr_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_set,
   input  logic any_cmd,
   output logic armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (arm_set) begin
         armed <= 1'b1;
      end else if (any_cmd) begin
         armed <= 1'b0;
      end
   end
endmodule

// File: rtl/flash_sr_gate.sv
module flash_sr_gate (
   input  logic sr_write,
   input  logic armed,
   input  logic wp_n,
   input  logic lock_bit,
   output logic accept
);
   logic lock_active;
   always_comb begin
      lock_active = lock_bit && !wp_n;
      accept      = sr_write && armed && !lock_active;
   end
endmodule

// File: rtl/flash_sr_prot.sv
module flash_sr_prot
   import flash_sr_pkg::*;
#(
   parameter int        ADDR_W   = 24,
   parameter int        ARRAY_AW = 21,
   parameter side_sel_e SIDE_SEL = SIDE_PIN
) (
   input  logic [PCODE_W-1:0] pcode,
   input  logic               bottom,
   input  logic [ADDR_W-1:0]  addr,
   output logic               prot,
   output logic               all_clear
);
   localparam int CODE_ALL = NUM_LVL + 1;

   logic [ARRAY_AW-1:0] offs;
   logic [NUM_LVL:1]    hi_ones;
   logic [NUM_LVL:1]    hi_zeros;
   logic                use_bottom;

   assign offs = addr[ARRAY_AW-1:0];

   for (genvar k = 1; k <= NUM_LVL; k++) begin : g_lvl
      assign hi_ones[k]  = &offs[ARRAY_AW-1 -: k];
      assign hi_zeros[k] = ~|offs[ARRAY_AW-1 -: k];
   end

   if (SIDE_SEL == SIDE_TOP) begin : g_top
      assign use_bottom = 1'b0;
   end else if (SIDE_SEL == SIDE_BOTTOM) begin : g_bot
      assign use_bottom = 1'b1;
   end else begin : g_pin
      assign use_bottom = bottom;
   end

   always_comb begin
      prot = 1'b0;
      if (int'(pcode) >= CODE_ALL) begin
         prot = 1'b1;
      end else begin
         for (int c = 1; c <= NUM_LVL; c++) begin
            if (int'(pcode) == c) begin
               prot = use_bottom ? hi_zeros[NUM_LVL + 1 - c] : hi_ones[NUM_LVL + 1 - c];
            end
         end
      end
      all_clear = (pcode == '0);
   end
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
   import flash_sr_pkg::*;
#(
   parameter int        ADDR_W   = 24,
   parameter int        ARRAY_AW = 21,
   parameter side_sel_e SIDE_SEL = SIDE_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_en,
   input  logic              cmd_wr_dis,
   input  logic              cmd_sr_arm,
   input  logic              cmd_sr_write,
   input  logic              cmd_other,
   input  logic [SR_W-1:0]   wr_data,
   input  logic              op_done,
   input  logic              busy_in,
   input  logic              aai_in,
   input  logic              wp_n,
   input  logic              prot_bottom,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic [SR_W-1:0]   status,
   output logic              addr_prot,
   output logic              chip_erase_ok
);
   if (ARRAY_AW < NUM_LVL || ARRAY_AW > ADDR_W) begin : g_bad_aw
      $error("flash_sr_guard: ARRAY_AW must lie between NUM_LVL and ADDR_W");
   end

   logic               armed;
   logic               wr_accept;
   logic               any_cmd;
   logic [PCODE_W-1:0] pcode_q;
   logic               lock_q;
   logic               wlatch_q;
   logic               busy_q;
   logic               aai_q;

   assign any_cmd = cmd_wr_en | cmd_wr_dis | cmd_sr_arm | cmd_sr_write | cmd_other;

   flash_sr_arm u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_set (cmd_wr_en | cmd_sr_arm),
      .any_cmd (any_cmd),
      .armed   (armed)
   );

   flash_sr_gate u_gate (
      .sr_write (cmd_sr_write),
      .armed    (armed),
      .wp_n     (wp_n),
      .lock_bit (lock_q),
      .accept   (wr_accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcode_q  <= PCODE_RESET;
         lock_q   <= 1'b0;
         wlatch_q <= 1'b0;
         busy_q   <= 1'b0;
         aai_q    <= 1'b0;
      end else begin
         busy_q <= busy_in;
         aai_q  <= aai_in;
         if (wr_accept) begin
            pcode_q  <= wr_data[SR_PCODE_HI:SR_PCODE_LO];
            lock_q   <= wr_data[SR_LOCK];
            wlatch_q <= 1'b0;
         end else if (cmd_wr_en) begin
            wlatch_q <= 1'b1;
         end else if (cmd_wr_dis || op_done) begin
            wlatch_q <= 1'b0;
         end
      end
   end

   always_comb begin
      status                          = '0;
      status[SR_BUSY]                 = busy_q;
      status[SR_WLATCH]               = wlatch_q;
      status[SR_PCODE_HI:SR_PCODE_LO] = pcode_q;
      status[SR_AAI]                  = aai_q;
      status[SR_LOCK]                 = lock_q;
   end

   flash_sr_prot #(
      .ADDR_W   (ADDR_W),
      .ARRAY_AW (ARRAY_AW),
      .SIDE_SEL (SIDE_SEL)
   ) u_prot (
      .pcode     (pcode_q),
      .bottom    (prot_bottom),
      .addr      (chk_addr),
      .prot      (addr_prot),
      .all_clear (chip_erase_ok)
   );
endmodule

// File: rtl/flash_sr_guard_chk.sv
module flash_sr_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wr_en,
   input logic       cmd_wr_dis,
   input logic       cmd_sr_write,
   input logic       armed,
   input logic       wp_n,
   input logic [7:0] status,
   input logic       addr_prot,
   input logic       chip_erase_ok
);
   // R1: reserved bit never set
   assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      status[5] == 1'b0);

   // R2: write disable without enable in same cycle clears the latch
   assert_wdis_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_dis && !cmd_wr_en) |=> !status[1]);

   // R3: unarmed status write leaves the writable bits alone
   assert_unarmed_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_sr_write && !armed) |=> $stable({status[7], status[4:2]}));

   // R4: accepted status write clears the write-enable latch
   assert_accept_wclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_sr_write && armed && (wp_n || !status[7])) |=> !status[1]);

   // R5: locked register holds while pin is low
   assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_sr_write && !wp_n && status[7]) |=> $stable({status[7], status[4:2]}));

   // R8: codes 6 and 7 protect every address
   assert_full_prot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status[4:3] == 2'b11) |-> addr_prot);

   // R10: erase permission implies nothing is protected
   assert_erase_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      chip_erase_ok |-> !addr_prot);
endmodule

bind flash_sr_guard flash_sr_guard_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_wr_en     (cmd_wr_en),
   .cmd_wr_dis    (cmd_wr_dis),
   .cmd_sr_write  (cmd_sr_write),
   .armed         (armed),
   .wp_n          (wp_n),
   .status        (status),
   .addr_prot     (addr_prot),
   .chip_erase_ok (chip_erase_ok)
);

// File: tb/flash_sr_guard_tb.sv
module flash_sr_guard_tb_top;
   localparam int K_WEN  = 0;
   localparam int K_WDIS = 1;
   localparam int K_ARM  = 2;
   localparam int K_SRW  = 3;
   localparam int K_OTH  = 4;
   localparam int K_DONE = 5;
   localparam int NVEC   = 16;

   // {protect code, bottom, address, expected protected}
   localparam logic [28:0] VEC [NVEC] = '{
      {3'd1, 1'b0, 24'h1F0000, 1'b1},
      {3'd1, 1'b0, 24'h1EFFFF, 1'b0},
      {3'd2, 1'b0, 24'h1E0000, 1'b1},
      {3'd3, 1'b0, 24'h1BFFFF, 1'b0},
      {3'd4, 1'b0, 24'h180000, 1'b1},
      {3'd5, 1'b0, 24'h0FFFFF, 1'b0},
      {3'd5, 1'b0, 24'h100000, 1'b1},
      {3'd6, 1'b0, 24'h000000, 1'b1},
      {3'd7, 1'b1, 24'h1FFFFF, 1'b1},
      {3'd0, 1'b0, 24'h1FFFFF, 1'b0},
      {3'd1, 1'b1, 24'h00FFFF, 1'b1},
      {3'd1, 1'b1, 24'h010000, 1'b0},
      {3'd3, 1'b1, 24'h03FFFF, 1'b1},
      {3'd5, 1'b1, 24'h100000, 1'b0},
      {3'd1, 1'b0, 24'hFFFFFF, 1'b1},
      {3'd1, 1'b1, 24'hE00000, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr_en = 0, cmd_wr_dis = 0, cmd_sr_arm = 0, cmd_sr_write = 0, cmd_other = 0;
   logic [7:0]  wr_data = '0;
   logic        op_done = 0, busy_in = 0, aai_in = 0;
   logic        wp_n = 1'b1, prot_bottom = 1'b0;
   logic [23:0] chk_addr = '0;
   logic [7:0]  status;
   logic        addr_prot, chip_erase_ok;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   flash_sr_guard dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_dis(cmd_wr_dis),
      .cmd_sr_arm(cmd_sr_arm), .cmd_sr_write(cmd_sr_write), .cmd_other(cmd_other),
      .wr_data(wr_data), .op_done(op_done), .busy_in(busy_in), .aai_in(aai_in),
      .wp_n(wp_n), .prot_bottom(prot_bottom), .chk_addr(chk_addr),
      .status(status), .addr_prot(addr_prot), .chip_erase_ok(chip_erase_ok)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic issue(input int kind, input logic [7:0] d);
      @(negedge clk);
      wr_data = d;
      case (kind)
         K_WEN:  cmd_wr_en = 1'b1;
         K_WDIS: cmd_wr_dis = 1'b1;
         K_ARM:  cmd_sr_arm = 1'b1;
         K_SRW:  cmd_sr_write = 1'b1;
         K_OTH:  cmd_other = 1'b1;
         default: op_done = 1'b1;
      endcase
      @(negedge clk);
      {cmd_wr_en, cmd_wr_dis, cmd_sr_arm, cmd_sr_write, cmd_other, op_done} = '0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 100000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset status", status, 8'h1C);
      chk("R10 reset erase gate", chip_erase_ok, 1'b0);
      chk("R8 reset protect", addr_prot, 1'b1);

      // R2 latch set and clear, and same-cycle collision
      issue(K_WEN, 8'h00);  chk("R2 set", status, 8'h1E);
      issue(K_WDIS, 8'h00); chk("R2 disable", status, 8'h1C);
      issue(K_WEN, 8'h00);
      issue(K_DONE, 8'h00); chk("R2 done clears", status, 8'h1C);
      @(negedge clk);
      cmd_wr_en = 1'b1; op_done = 1'b1;
      @(negedge clk);
      cmd_wr_en = 1'b0; op_done = 1'b0;
      chk("R2 enable wins over done", status, 8'h1E);
      issue(K_DONE, 8'h00);

      // R3 arming rules
      issue(K_OTH, 8'h00);
      issue(K_SRW, 8'h00); chk("R3 unarmed ignored", status, 8'h1C);
      issue(K_ARM, 8'h00);
      repeat (3) @(negedge clk);
      issue(K_SRW, 8'h00); chk("R3 idle keeps arm", status, 8'h00);
      issue(K_ARM, 8'h00);
      issue(K_WDIS, 8'h00);
      issue(K_SRW, 8'h1C); chk("R3 disable cancels arm", status, 8'h00);
      issue(K_WEN, 8'h00);
      issue(K_OTH, 8'h00);
      issue(K_SRW, 8'h1C); chk("R3 other cancels arm", status, 8'h02);
      issue(K_WDIS, 8'h00);

      // R4 field mask and latch clear
      issue(K_WEN, 8'h00);
      issue(K_SRW, 8'hFF); chk("R4 masked load", status, 8'h9C);

      // R5 locked with pin low
      wp_n = 1'b0;
      issue(K_WEN, 8'h00);
      issue(K_SRW, 8'h00); chk("R5 locked via enable", status, 8'h9E);
      issue(K_ARM, 8'h00);
      issue(K_SRW, 8'h00); chk("R5 locked via arm", status, 8'h9E);
      issue(K_WDIS, 8'h00);

      // R7 pin high overrides lock
      wp_n = 1'b1;
      issue(K_ARM, 8'h00);
      issue(K_SRW, 8'h00); chk("R7 unlock with pin high", status, 8'h00);

      // R6 set lock and code together with pin low
      wp_n = 1'b0;
      issue(K_ARM, 8'h00);
      issue(K_SRW, 8'h88); chk("R6 lock and code", status, 8'h88);
      issue(K_ARM, 8'h00);
      issue(K_SRW, 8'h00); chk("R6 lock now one-way", status, 8'h88);
      wp_n = 1'b1;

      // R11 mirrored flags
      @(negedge clk);
      busy_in = 1'b1; aai_in = 1'b1;
      @(negedge clk);
      chk("R11 busy bit", status[0], 1'b1);
      chk("R11 auto-increment bit", status[6], 1'b1);
      busy_in = 1'b0; aai_in = 1'b0;
      @(negedge clk);
      chk("R11 flags drop", {status[6], status[0]}, 2'b00);

      // R8 R9 R10 protection table
      for (int i = 0; i < NVEC; i++) begin
         issue(K_WEN, 8'h00);
         issue(K_SRW, {3'b000, VEC[i][28:26], 2'b00});
         prot_bottom = VEC[i][25];
         chk_addr    = VEC[i][24:1];
         #2;
         if (VEC[i][25])
            chk($sformatf("R9 vector %0d", i), addr_prot, VEC[i][0]);
         else
            chk($sformatf("R8 vector %0d", i), addr_prot, VEC[i][0]);
         chk($sformatf("R10 vector %0d", i), chip_erase_ok, VEC[i][28:26] == 3'd0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule